// File: doc/BRIEF.md
# Four-Mode Inversion Link Encoder

This block sits at the transmit end of an on-chip network link. It takes a stream of body-flit payloads and, for each one, picks one of four ways to put it on the wires: unchanged, with the odd-indexed bits complemented, with the even-indexed bits complemented, or with every bit complemented. It picks the version whose switching cost, measured against the flit it sent last, is lowest. Coupling between neighbouring wires dominates that cost. A two-bit mode code travels beside the encoded payload so that the far end can undo the inversion. A combinational decoder is part of the block, and it shows the recovered payload on its own port.

The input side is valid/ready. A flit is taken on a rising clock edge when `in_valid` and `in_ready` are both high. The output side is a single register stage that holds the encoded flit and its mode code. That stage can take a new flit when it is empty or when its current flit is leaving in the same cycle, so `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output holds still and no input is taken. The encoded flit that was accepted last is the reference for the next decision. It changes only on an accepted transfer, and reset clears it to zero.

Top module: `lnk_inv_encoder`

## Requirements
- R1: After reset, `out_valid` is 0 and the reference flit is all zeros, so the first flit's cost is measured against zero.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A flit is accepted on a clock edge with `in_valid && in_ready`.
- R3: While `out_valid` is high and `out_ready` is low, `out_data` and `out_mode` stay unchanged and `out_valid` stays high.
- R4: An accepted flit appears on `out_data`/`out_mode` with `out_valid` high on the edge that accepts it. If the output is taken and no new flit is accepted, `out_valid` falls on that edge.
- R5: The mode codes are as follows. `00` sends the payload as is. `10` complements the bits at odd indices (1, 3, 5, ...). `01` complements the bits at even indices (0, 2, 4, ...). `11` complements all bits.
- R6: The cost of a candidate C against reference F is computed from the per-bit toggles T = C xor F. It is the number of set bits of T plus a weight for each adjacent pair (i, i+1). The weight is 1 when exactly one bit of the pair toggles. It is 2 when both toggle in opposite directions (C[i] != C[i+1]). Otherwise it is 0.
- R7: The emitted encoding has the lowest R6 cost of the four candidates.
- R8: When candidates tie on cost, the first in the order none, odd, even, full is chosen.
- R9: The reference flit updates only on an accepted transfer. Stalled or idle cycles leave it unchanged.
- R10: `dec_data` equals `out_data` with the R5 mask for `out_mode` applied. It therefore always equals the payload that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Block can accept a payload this cycle |
| in_data | input | PW | Payload |
| out_valid | output | 1 | Encoded flit present |
| out_ready | input | 1 | Downstream takes the encoded flit |
| out_data | output | PW | Encoded payload wires |
| out_mode | output | 2 | Inversion mode code (R5) |
| dec_data | output | PW | Payload recovered by the built-in decoder |

## Verification
A corrupted reference flit does not break the round trip. It shows up as a wrong mode code on the very next accepted flit, one edge after acceptance, as soon as the bench's cost model disagrees about which candidate is cheapest. A wrong mask or a wrong mode select shows on `dec_data` in the same cycle the flit appears. A bad hold path shows as `out_data` moving during a stall. The bench therefore compares the mode, the encoded data, the cost of the emitted data and the decoded payload on every flit, and it does this across stalls and resets.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_EVEN = 2'b01,
    MODE_ODD  = 2'b10,
    MODE_FULL = 2'b11
  } lnk_mode_e;

  // candidate index order doubles as tie-break order
  localparam int CAND_NONE = 0;
  localparam int CAND_ODD  = 1;
  localparam int CAND_EVEN = 2;
  localparam int CAND_FULL = 3;
  localparam int NCAND     = 4;
endpackage

// File: rtl/lnk_cand_cost.sv
module lnk_cand_cost #(
  parameter int PW = 16,
  parameter int CW = $clog2(3 * PW)
) (
  input  logic [PW-1:0] ref_flit,
  input  logic [PW-1:0] cand,
  output logic [CW-1:0] cost
);
  logic [PW-1:0] tg;
  logic [1:0]    pair_w [PW-1];

  assign tg = ref_flit ^ cand;

  // per-pair coupling detectors
  for (genvar gi = 0; gi < PW - 1; gi++) begin : g_pair
    always_comb begin
      if (tg[gi] ^ tg[gi+1])
        pair_w[gi] = 2'd1;
      else if (tg[gi] && tg[gi+1] && (cand[gi] != cand[gi+1]))
        pair_w[gi] = 2'd2;
      else
        pair_w[gi] = 2'd0;
    end
  end

  always_comb begin
    cost = '0;
    for (int i = 0; i < PW; i++)
      cost = cost + CW'(tg[i]);
    for (int i = 0; i < PW - 1; i++)
      cost = cost + CW'(pair_w[i]);
  end
endmodule

// File: rtl/lnk_mode_pick.sv
module lnk_mode_pick
  import lnk_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic [CW-1:0] cost_none,
  input  logic [CW-1:0] cost_odd,
  input  logic [CW-1:0] cost_even,
  input  logic [CW-1:0] cost_full,
  output lnk_mode_e     mode
);
  logic [CW-1:0] best;

  // strict compares keep the earlier candidate on a tie
  always_comb begin
    mode = MODE_NONE;
    best = cost_none;
    if (cost_odd < best) begin
      mode = MODE_ODD;
      best = cost_odd;
    end
    if (cost_even < best) begin
      mode = MODE_EVEN;
      best = cost_even;
    end
    if (cost_full < best) begin
      mode = MODE_FULL;
      best = cost_full;
    end
  end
endmodule

// File: rtl/lnk_decoder.sv
module lnk_decoder #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] enc,
  input  logic [1:0]    mode,
  output logic [PW-1:0] dec
);
  logic [PW-1:0] odd_m;
  logic [PW-1:0] msk;

  for (genvar gi = 0; gi < PW; gi++) begin : g_mask
    assign odd_m[gi] = (gi % 2) == 1;
  end

  always_comb begin
    unique case (mode)
      2'b10:   msk = odd_m;
      2'b01:   msk = ~odd_m;
      2'b11:   msk = '1;
      default: msk = '0;
    endcase
  end

  assign dec = enc ^ msk;
endmodule

// File: rtl/lnk_inv_encoder.sv
module lnk_inv_encoder
  import lnk_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data,
  output logic [1:0]    out_mode,
  output logic [PW-1:0] dec_data
);
  localparam int CW = $clog2(3 * PW);

  logic [PW-1:0] odd_m;
  logic [PW-1:0] cand [NCAND];
  logic [CW-1:0] cost [NCAND];
  logic [PW-1:0] ref_q;
  logic [1:0]    mode_q;
  logic          vld_q;
  lnk_mode_e     pick;
  logic [PW-1:0] pick_flit;
  logic [CW-1:0] pick_cost;
  logic          accept;

  for (genvar gi = 0; gi < PW; gi++) begin : g_mask
    assign odd_m[gi] = (gi % 2) == 1;
  end

  assign cand[CAND_NONE] = in_data;
  assign cand[CAND_ODD]  = in_data ^ odd_m;
  assign cand[CAND_EVEN] = in_data ^ ~odd_m;
  assign cand[CAND_FULL] = ~in_data;

  for (genvar gc = 0; gc < NCAND; gc++) begin : g_cost
    lnk_cand_cost #(.PW(PW), .CW(CW)) u_cost (
      .ref_flit (ref_q),
      .cand     (cand[gc]),
      .cost     (cost[gc])
    );
  end

  lnk_mode_pick #(.CW(CW)) u_pick (
    .cost_none (cost[CAND_NONE]),
    .cost_odd  (cost[CAND_ODD]),
    .cost_even (cost[CAND_EVEN]),
    .cost_full (cost[CAND_FULL]),
    .mode      (pick)
  );

  always_comb begin
    unique case (pick)
      MODE_ODD:  begin pick_flit = cand[CAND_ODD];  pick_cost = cost[CAND_ODD];  end
      MODE_EVEN: begin pick_flit = cand[CAND_EVEN]; pick_cost = cost[CAND_EVEN]; end
      MODE_FULL: begin pick_flit = cand[CAND_FULL]; pick_cost = cost[CAND_FULL]; end
      default:   begin pick_flit = cand[CAND_NONE]; pick_cost = cost[CAND_NONE]; end
    endcase
  end

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  // output register doubles as the reference flit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      ref_q  <= '0;
      mode_q <= 2'b00;
    end else if (accept) begin
      vld_q  <= 1'b1;
      ref_q  <= pick_flit;
      mode_q <= pick;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = ref_q;
  assign out_mode  = mode_q;

  lnk_decoder #(.PW(PW)) u_dec (
    .enc  (ref_q),
    .mode (mode_q),
    .dec  (dec_data)
  );

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_mode)));

  // R4
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (dec_data == $past(in_data)));

  // R7
  min_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (pick_cost <= cost[CAND_NONE] && pick_cost <= cost[CAND_ODD] &&
                  pick_cost <= cost[CAND_EVEN] && pick_cost <= cost[CAND_FULL]));

  // R8
  tie_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pick == MODE_FULL) |-> (cost[CAND_FULL] < cost[CAND_NONE] &&
     cost[CAND_FULL] < cost[CAND_ODD] && cost[CAND_FULL] < cost[CAND_EVEN]));

  // R9
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_data));
endmodule

// File: tb/lnk_inv_encoder_test.sv
module lnk_inv_encoder_test;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [PW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [PW-1:0] out_data;
  logic [1:0]    out_mode;
  logic [PW-1:0] dec_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [PW-1:0] ref_m = '0;

  always #10 clk = ~clk;

  lnk_inv_encoder #(.PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_mode(out_mode), .dec_data(dec_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R5 masks, index 0 none, 1 odd, 2 even, 3 full
  function automatic logic [PW-1:0] msk(input int k);
    logic [PW-1:0] m;
    for (int i = 0; i < PW; i++) begin
      case (k)
        1:       m[i] = (i % 2) == 1;
        2:       m[i] = (i % 2) == 0;
        3:       m[i] = 1'b1;
        default: m[i] = 1'b0;
      endcase
    end
    return m;
  endfunction

  function automatic logic [1:0] code(input int k);
    case (k)
      1:       return 2'b10;
      2:       return 2'b01;
      3:       return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // R6 cost
  function automatic int cost(input logic [PW-1:0] f, input logic [PW-1:0] c);
    logic [PW-1:0] t;
    int s;
    t = f ^ c;
    s = 0;
    for (int i = 0; i < PW; i++) s += int'(t[i]);
    for (int i = 0; i < PW - 1; i++) begin
      if (t[i] != t[i+1]) s += 1;
      else if (t[i] && c[i] != c[i+1]) s += 2;
    end
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R2", 32'(in_ready), 1);
    rst_n = 1'b1;
    ref_m = '0;
  endtask

  // called at a negedge; returns at a negedge
  task automatic push(input logic [PW-1:0] d, input bit stall);
    int c[4];
    int best;
    int nmin;
    logic [PW-1:0] enc;
    for (int k = 0; k < 4; k++) c[k] = cost(ref_m, d ^ msk(k));
    best = 0;
    for (int k = 1; k < 4; k++) if (c[k] < c[best]) best = k;
    nmin = 0;
    for (int k = 0; k < 4; k++) if (c[k] == c[best]) nmin++;
    enc = d ^ msk(best);
    in_valid = 1'b1; in_data = d; out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R2", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R4", 32'(out_valid), 1);
    if (nmin > 1)
      chk(out_mode == code(best), "R8", 32'(out_mode), 32'(code(best)));
    else
      chk(out_mode == code(best), "R5", 32'(out_mode), 32'(code(best)));
    chk(out_data == enc, "R6", 32'(out_data), 32'(enc));
    chk(cost(ref_m, out_data) == c[best], "R7", 32'(cost(ref_m, out_data)), 32'(c[best]));
    chk(dec_data == d, "R10", 32'(dec_data), 32'(d));
    ref_m = enc;
    if (stall) begin
      out_ready = 1'b0; in_valid = 1'b1; in_data = ~d;
      for (int n = 0; n < 3; n++) begin
        @(negedge clk);
        chk(in_ready == 1'b0, "R2", 32'(in_ready), 0);
        chk(out_valid && out_data == enc && out_mode == code(best), "R3",
            32'(out_data), 32'(enc));
      end
      in_valid = 1'b0; out_ready = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R4", 32'(out_valid), 0);
      chk(out_data == enc, "R9", 32'(out_data), 32'(enc));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] v;
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    // R1: first flit against a zero reference; even-index pattern -> even mode
    push(16'h5555, 1'b0);
    push(16'h5555 ^ 16'hFFFF, 1'b0);
    push(16'h0000, 1'b1);
    push(16'hFFFF, 1'b0);
    push(16'hFFFF, 1'b0);
    push(16'h0F0F, 1'b1);
    // R9: idle cycle does not move the reference
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4", 32'(out_valid), 0);
    push(16'h3C3C, 1'b0);
    // R1: reset mid-stream clears the reference
    do_reset();
    @(negedge clk);
    push(16'hFFFF, 1'b0);
    push(16'hAAAA, 1'b0);
    // random stream
    for (int n = 0; n < 150; n++) push(PW'($urandom), ($urandom % 8) == 0);
    // correlated stream
    v = PW'($urandom);
    for (int n = 0; n < 150; n++) begin
      v = v ^ (PW'(1) << ($urandom % PW));
      if (($urandom % 4) == 0) v = v + PW'(1);
      push(v, ($urandom % 10) == 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule